// File: doc/BRIEF.md
# Single-Cycle Execution Unit with Scratchpad

This block is the datapath of a small processor. It takes an 18-bit instruction word and a valid qualifier. In the same clock edge it decodes the word, reads its operands and writes the result back. It holds a register file, an optional scratchpad RAM, and a zero flag and a carry flag. The instructions it executes are: load from scratchpad, bitwise AND, compare, add, and add with carry.

Each operation has two forms. In one form the second operand is an 8-bit constant from the instruction. In the other form it is a second register. Opcode bit 12 picks between the two. An instruction presented with the valid input low has no effect, so the sequencer can squash an instruction that is already in flight.

Storing into the scratchpad belongs to logic outside this block. That logic writes the scratchpad through a fill port. A read port lets the surrounding logic see any register, which the output path of the processor needs. With the scratchpad address width set to 0, the RAM is left out and a load has no effect.

Top module: `exu_core`

## Requirements
- R1: After reset, all registers read 0, both flags are 0, and every scratchpad entry holds 0.
- R2: FETCH (opcode bits 17..12 = 000110 for the constant form, 000111 for the register form) loads the scratchpad entry into register sX (bits 11..8). In the constant form the address is the constant; in the register form it is the value of sY. The flags do not change.
- R3: AND (001010 / 001011) writes sX AND the operand into sX. It clears the carry flag and sets the zero flag when the result is 0.
- R4: COMPARE (010100 / 010101) leaves sX unchanged. It sets the carry flag when sX is less than the operand (unsigned) and sets the zero flag when the two are equal.
- R5: ADD (011000 / 011001) writes (sX + operand) mod 2^8 into sX. The carry flag becomes the carry out of the top bit, and the zero flag is set when the 8-bit result is 0.
- R6: ADDCY (011010 / 011011) behaves like ADD but also adds the carry flag as it stood before the instruction.
- R7: When opcode bit 12 is 1, the second operand is the register addressed by bits 7..4, and bits 3..0 are ignored. When bit 12 is 0, the second operand is bits 7..0.
- R8: While the valid input is low, no register or flag changes, whatever the instruction word holds.
- R9: A valid instruction with any other opcode (for example 111111) changes no register and no flag.
- R10: With a scratchpad address width of 0, FETCH changes neither sX nor the flags.
- R11: A fill-port write lands in the scratchpad at the clock edge. A FETCH of the same address in the same cycle returns the value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | Qualifies instr for execution this cycle |
| instr | input | 18 | Instruction word |
| fill_en | input | 1 | Scratchpad fill write enable |
| fill_addr | input | max(SP_AW,1) | Scratchpad fill address |
| fill_data | input | DATA_W | Scratchpad fill data |
| rd_addr | input | REG_AW | Register read-port address |
| rd_data | output | DATA_W | Combinational value of the addressed register |
| zero_o | output | 1 | Zero flag |
| carry_o | output | 1 | Carry flag |

## Verification
The assertions take for granted that reset is asserted at time zero and that the instruction word and fill inputs are settled before each rising edge. They also take the register file and the scratchpad to start empty. Only the compare-flag property relies on the operands sampled in the cycle before. The bench changes inputs only on the falling edge and reads results one cycle later, after the edge. Its random words are drawn from the five defined operation classes, with the valid input dropped at times and a few undefined opcodes added. It does not set both instruction fields and fill fields to the same scratchpad address unless the same-cycle ordering is the case under test.

// File: rtl/exu_pkg.sv
package exu_pkg;

    localparam int INSTR_W = 18;

    typedef enum logic [2:0] {
        K_NONE,
        K_FETCH,
        K_AND,
        K_CMP,
        K_ADD,
        K_ADDC
    } kind_e;

    typedef struct packed {
        kind_e       kind;
        logic        use_reg;
        logic [3:0]  sx;
        logic [3:0]  sy;
        logic [7:0]  kk;
    } dec_t;

endpackage

// File: rtl/exu_decode.sv
module exu_decode
    import exu_pkg::*;
(
    input  logic               valid_i,
    input  logic [INSTR_W-1:0] instr_i,
    output dec_t               dec_o
);
    logic [4:0] op_class;

    always_comb begin
        op_class      = instr_i[17:13];
        dec_o.use_reg = instr_i[12];
        dec_o.sx      = instr_i[11:8];
        dec_o.sy      = instr_i[7:4];
        dec_o.kk      = instr_i[7:0];
        unique case (op_class)
            5'b00011: dec_o.kind = K_FETCH;
            5'b00101: dec_o.kind = K_AND;
            5'b01010: dec_o.kind = K_CMP;
            5'b01100: dec_o.kind = K_ADD;
            5'b01101: dec_o.kind = K_ADDC;
            default:  dec_o.kind = K_NONE;
        endcase
        if (!valid_i) dec_o.kind = K_NONE;
    end
endmodule

// File: rtl/exu_alu.sv
module exu_alu
    import exu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  kind_e              kind_i,
    input  logic [DATA_W-1:0]  a_i,
    input  logic [DATA_W-1:0]  b_i,
    input  logic [DATA_W-1:0]  load_i,
    input  logic               carry_i,
    input  logic               zero_i,
    output logic               wr_en_o,
    output logic [DATA_W-1:0]  res_o,
    output logic               flag_en_o,
    output logic               carry_o,
    output logic               zero_o
);
    logic [DATA_W:0] sum;
    logic [DATA_W:0] diff;
    logic [DATA_W:0] cin_ext;

    always_comb begin
        cin_ext   = (DATA_W+1)'(kind_i == K_ADDC ? carry_i : 1'b0);
        sum       = {1'b0, a_i} + {1'b0, b_i} + cin_ext;
        diff      = {1'b0, a_i} - {1'b0, b_i};
        wr_en_o   = 1'b0;
        flag_en_o = 1'b0;
        res_o     = '0;
        carry_o   = carry_i;
        zero_o    = zero_i;
        unique case (kind_i)
            K_FETCH: begin
                wr_en_o = 1'b1;
                res_o   = load_i;
            end
            K_AND: begin
                wr_en_o   = 1'b1;
                flag_en_o = 1'b1;
                res_o     = a_i & b_i;
                carry_o   = 1'b0;
                zero_o    = ((a_i & b_i) == '0);
            end
            K_CMP: begin
                flag_en_o = 1'b1;
                carry_o   = diff[DATA_W];
                zero_o    = (diff[DATA_W-1:0] == '0);
            end
            K_ADD, K_ADDC: begin
                wr_en_o   = 1'b1;
                flag_en_o = 1'b1;
                res_o     = sum[DATA_W-1:0];
                carry_o   = sum[DATA_W];
                zero_o    = (sum[DATA_W-1:0] == '0);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/exu_scratch.sv
module exu_scratch #(
    parameter int DATA_W = 8,
    parameter int SP_AW  = 4,
    localparam int SP_AWX = (SP_AW > 0) ? SP_AW : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SP_AWX-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              wen_i,
    input  logic [SP_AWX-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i
);
    generate
        if (SP_AW > 0) begin : g_ram
            localparam int DEPTH = 1 << SP_AW;
            logic [DEPTH-1:0][DATA_W-1:0] mem_d, mem_q;

            always_comb begin
                mem_d = mem_q;
                if (wen_i) mem_d[waddr_i] = wdata_i;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) mem_q <= '0;
                else        mem_q <= mem_d;
            end

            assign rdata_o = mem_q[raddr_i];

            // R11: a fill write is visible at its address one edge later
            p_fill_lands_r11: assert property (@(posedge clk) disable iff (!rst_n)
                wen_i |=> mem_q[$past(waddr_i)] == $past(wdata_i));
        end else begin : g_none
            assign rdata_o = '0;
        end
    endgenerate
endmodule

// File: rtl/exu_core.sv
module exu_core
    import exu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int REG_AW = 4,
    parameter int SP_AW  = 4,
    localparam int SP_AWX = (SP_AW > 0) ? SP_AW : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               instr_valid,
    input  logic [INSTR_W-1:0] instr,
    input  logic               fill_en,
    input  logic [SP_AWX-1:0]  fill_addr,
    input  logic [DATA_W-1:0]  fill_data,
    input  logic [REG_AW-1:0]  rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    output logic               zero_o,
    output logic               carry_o
);
    localparam int NREG   = 1 << REG_AW;
    localparam bit HAS_SP = (SP_AW > 0);

    typedef struct packed {
        logic [NREG-1:0][DATA_W-1:0] rf;
        logic                        z;
        logic                        c;
    } state_t;

    state_t             st_d, st_q;
    dec_t               dec;
    kind_e              kind_eff;
    logic [REG_AW-1:0]  sx_idx, sy_idx;
    logic [DATA_W-1:0]  op_a, op_b, imm_ext, sp_rdata, alu_res;
    logic [SP_AWX-1:0]  sp_raddr;
    logic               alu_we, alu_fe, alu_c, alu_z;

    exu_decode u_dec (
        .valid_i (instr_valid),
        .instr_i (instr),
        .dec_o   (dec)
    );

    always_comb begin
        sx_idx   = dec.sx[REG_AW-1:0];
        sy_idx   = dec.sy[REG_AW-1:0];
        imm_ext  = DATA_W'(dec.kk);
        op_a     = st_q.rf[sx_idx];
        op_b     = dec.use_reg ? st_q.rf[sy_idx] : imm_ext;
        sp_raddr = dec.use_reg ? st_q.rf[sy_idx][SP_AWX-1:0] : dec.kk[SP_AWX-1:0];
        kind_eff = (dec.kind == K_FETCH && !HAS_SP) ? K_NONE : dec.kind;
    end

    exu_scratch #(.DATA_W(DATA_W), .SP_AW(SP_AW)) u_sp (
        .clk     (clk),
        .rst_n   (rst_n),
        .raddr_i (sp_raddr),
        .rdata_o (sp_rdata),
        .wen_i   (fill_en),
        .waddr_i (fill_addr),
        .wdata_i (fill_data)
    );

    exu_alu #(.DATA_W(DATA_W)) u_alu (
        .kind_i    (kind_eff),
        .a_i       (op_a),
        .b_i       (op_b),
        .load_i    (sp_rdata),
        .carry_i   (st_q.c),
        .zero_i    (st_q.z),
        .wr_en_o   (alu_we),
        .res_o     (alu_res),
        .flag_en_o (alu_fe),
        .carry_o   (alu_c),
        .zero_o    (alu_z)
    );

    always_comb begin
        st_d = st_q;
        if (alu_we) st_d.rf[sx_idx] = alu_res;
        if (alu_fe) begin
            st_d.z = alu_z;
            st_d.c = alu_c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.rf[rd_addr];
    assign zero_o  = st_q.z;
    assign carry_o = st_q.c;

    // R8: a squashed cycle leaves all state alone
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> $stable(st_q));

    // R9: undefined opcodes touch nothing
    p_undef_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.kind == K_NONE) |=> $stable(st_q));

    // R3: AND always leaves carry clear
    p_and_clears_c_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.kind == K_AND) |=> !carry_o);

    // R4: compare writes no register and sets zero on equality
    p_cmp_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.kind == K_CMP) |=> $stable(st_q.rf));
    p_cmp_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.kind == K_CMP) |=> zero_o == ($past(op_a) == $past(op_b)));

    // R2: a load keeps both flags
    p_fetch_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.kind == K_FETCH) |=> $stable({zero_o, carry_o}));
endmodule

// File: tb/exu_core_test.sv
`timescale 1ns/1ps
module exu_core_test;
    localparam real PERIOD = 10.0;

    localparam logic [5:0] OP_FETCH = 6'b000110;
    localparam logic [5:0] OP_AND   = 6'b001010;
    localparam logic [5:0] OP_CMP   = 6'b010100;
    localparam logic [5:0] OP_ADD   = 6'b011000;
    localparam logic [5:0] OP_ADDC  = 6'b011010;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [17:0] instr = '0;
    logic        fill_en = 1'b0;
    logic [3:0]  fill_addr = '0;
    logic [7:0]  fill_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        zero_o, carry_o;

    logic        n_valid = 1'b0;
    logic [17:0] n_instr = '0;
    logic [3:0]  n_rd_addr = '0;
    logic [7:0]  n_rd_data;
    logic        n_zero, n_carry;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [7:0] m_rf [16];
    logic [7:0] m_sp [16];
    logic       mz, mc;

    always #(PERIOD/2) clk = ~clk;

    exu_core uut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .fill_en(fill_en), .fill_addr(fill_addr), .fill_data(fill_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .zero_o(zero_o), .carry_o(carry_o)
    );

    exu_core #(.SP_AW(0)) uut_nosp (
        .clk(clk), .rst_n(rst_n), .instr_valid(n_valid), .instr(n_instr),
        .fill_en(1'b0), .fill_addr(1'b0), .fill_data(8'h00),
        .rd_addr(n_rd_addr), .rd_data(n_rd_data), .zero_o(n_zero), .carry_o(n_carry)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input logic v, input logic [17:0] ins);
        if (!v) return "R8";
        case (ins[17:13])
            5'b00011: return "R2";
            5'b00101: return "R3";
            5'b01010: return "R4";
            5'b01100: return "R5";
            5'b01101: return "R6";
            default:  return "R9";
        endcase
    endfunction

    function automatic void model(input logic v, input logic [17:0] ins);
        logic [3:0] sx, sy;
        logic [7:0] a, b, r;
        logic [8:0] s;
        sx = ins[11:8];
        sy = ins[7:4];
        a  = m_rf[sx];
        b  = ins[12] ? m_rf[sy] : ins[7:0];
        if (!v) return;
        case (ins[17:13])
            5'b00011: m_rf[sx] = m_sp[ins[12] ? m_rf[sy][3:0] : ins[3:0]];
            5'b00101: begin r = a & b; m_rf[sx] = r; mc = 1'b0; mz = (r == 0); end
            5'b01010: begin mc = (a < b); mz = (a == b); end
            5'b01100, 5'b01101: begin
                s = {1'b0, a} + {1'b0, b} + ((ins[13] ? 9'(mc) : 9'd0));
                m_rf[sx] = s[7:0]; mc = s[8]; mz = (s[7:0] == 0);
            end
            default: ;
        endcase
    endfunction

    function automatic logic [17:0] mk(input logic [5:0] op, input logic r,
                                       input logic [3:0] sx, input logic [7:0] low);
        return {op[5:1], r, sx, low};
    endfunction

    task automatic step(input logic v, input logic [17:0] ins,
                        input logic fe, input logic [3:0] fa, input logic [7:0] fd);
        string t;
        t = tag_of(v, ins);
        @(negedge clk);
        instr_valid = v; instr = ins;
        fill_en = fe; fill_addr = fa; fill_data = fd;
        model(v, ins);
        if (fe) m_sp[fa] = fd;
        @(posedge clk);
        #1;
        instr_valid = 1'b0; fill_en = 1'b0;
        rd_addr = ins[11:8];
        #1;
        chk({t, " reg"}, 32'(rd_data), 32'(m_rf[ins[11:8]]));
        chk({t, " zero"}, 32'(zero_o), 32'(mz));
        chk({t, " carry"}, 32'(carry_o), 32'(mc));
    endtask

    task automatic step_nosp(input logic [17:0] ins);
        @(negedge clk);
        n_valid = 1'b1; n_instr = ins;
        @(posedge clk);
        #1;
        n_valid = 1'b0;
        n_rd_addr = ins[11:8];
        #1;
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [17:0] ins;
        logic [2:0]  cls;
        logic [5:0]  op;
        void'($urandom(32'd1234));
        for (int i = 0; i < 16; i++) begin m_rf[i] = '0; m_sp[i] = '0; end
        mz = 0; mc = 0;
        #(PERIOD * 3);
        // R1: reset state
        for (int i = 0; i < 16; i++) begin
            rd_addr = 4'(i);
            #0.2;
            chk("R1 reg after reset", 32'(rd_data), 32'd0);
        end
        chk("R1 zero after reset", 32'(zero_o), 32'd0);
        chk("R1 carry after reset", 32'(carry_o), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b1, mk(OP_FETCH, 1'b0, 4'd3, 8'h09), 1'b0, 4'd0, 8'd0);
        chk("R1 scratch after reset", 32'(rd_data), 32'd0);

        // fill scratchpad (R11)
        for (int i = 0; i < 16; i++)
            step(1'b0, 18'h0, 1'b1, 4'(i), 8'($urandom));
        step(1'b1, mk(OP_FETCH, 1'b0, 4'd5, 8'h07), 1'b0, 4'd0, 8'd0);
        chk("R11 fill then fetch", 32'(rd_data), 32'(m_sp[7]));

        // directed arithmetic corners
        step(1'b1, mk(OP_ADD, 1'b0, 4'd1, 8'hFF), 1'b0, 4'd0, 8'd0);
        step(1'b1, mk(OP_ADD, 1'b0, 4'd1, 8'h01), 1'b0, 4'd0, 8'd0);   // R5 wrap: 0, C=1, Z=1
        chk("R5 wrap carry", 32'(carry_o), 32'd1);
        chk("R5 wrap zero", 32'(zero_o), 32'd1);
        step(1'b1, mk(OP_ADDC, 1'b0, 4'd1, 8'h10), 1'b0, 4'd0, 8'd0);  // R6: 0+10+1
        chk("R6 carry in used", 32'(rd_data), 32'h11);
        step(1'b1, mk(OP_ADD, 1'b0, 4'd2, 8'h11), 1'b0, 4'd0, 8'd0);
        step(1'b1, mk(OP_CMP, 1'b1, 4'd1, 8'h2F), 1'b0, 4'd0, 8'd0);   // R4/R7: r1 vs r2 equal
        chk("R4 equal zero", 32'(zero_o), 32'd1);
        chk("R7 low nibble ignored", 32'(carry_o), 32'd0);
        step(1'b1, mk(OP_CMP, 1'b0, 4'd1, 8'h12), 1'b0, 4'd0, 8'd0);   // R4 less
        chk("R4 less carry", 32'(carry_o), 32'd1);
        step(1'b1, mk(OP_AND, 1'b0, 4'd1, 8'h00), 1'b0, 4'd0, 8'd0);   // R3 zero result
        chk("R3 zero result", 32'(zero_o), 32'd1);
        step(1'b1, mk(OP_ADD, 1'b0, 4'd4, 8'h03), 1'b0, 4'd0, 8'd0);
        step(1'b1, mk(OP_FETCH, 1'b1, 4'd6, 8'h40), 1'b0, 4'd0, 8'd0); // R2 reg form
        chk("R2 register address", 32'(rd_data), 32'(m_sp[3]));
        step(1'b0, mk(OP_ADD, 1'b0, 4'd2, 8'h55), 1'b0, 4'd0, 8'd0);   // R8
        chk("R8 squashed add", 32'(rd_data), 32'h11);
        step(1'b1, {6'b111111, 4'd2, 8'hAA}, 1'b0, 4'd0, 8'd0);        // R9
        chk("R9 undefined opcode", 32'(rd_data), 32'h11);
        // R11 same-cycle collision: fetch returns old content
        step(1'b1, mk(OP_FETCH, 1'b0, 4'd8, 8'h0A), 1'b1, 4'd10, 8'h5A);
        step(1'b1, mk(OP_FETCH, 1'b0, 4'd9, 8'h0A), 1'b0, 4'd0, 8'd0);
        chk("R11 new content after edge", 32'(rd_data), 32'h5A);

        // constrained random mix
        for (int n = 0; n < 400; n++) begin
            cls = 3'($urandom_range(0, 5));
            case (cls)
                3'd0: op = OP_FETCH;
                3'd1: op = OP_AND;
                3'd2: op = OP_CMP;
                3'd3: op = OP_ADD;
                3'd4: op = OP_ADDC;
                default: op = 6'b100000;
            endcase
            ins = mk(op, 1'($urandom), 4'($urandom), 8'($urandom));
            step(($urandom_range(0, 9) != 0), ins, 1'b0, 4'd0, 8'd0);
        end

        // R10: no scratchpad
        step_nosp(mk(OP_ADD, 1'b0, 4'd2, 8'h55));
        step_nosp(mk(OP_FETCH, 1'b0, 4'd2, 8'h01));
        chk("R10 fetch without scratchpad reg", 32'(n_rd_data), 32'h55);
        chk("R10 fetch without scratchpad zero", 32'(n_zero), 32'd0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule